// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on a single output line. The line rests high. When a character is handed over, the block sends a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. A free-running enable from the surrounding logic pulses once per sixteenth of a bit period, and the block measures every bit, and every part of a bit, in those pulses.

The framing is chosen per character. A 2-bit code sets the data width from 5 to 8 bits. A 2-bit code sets the parity: none, even or odd. A 2-bit code sets the stop period to one, one and a half or two bit times. All three codes and the character are captured in the cycle the character is accepted. Changing them later has no effect on the frame in flight. The load side is a valid/ready pair, and a busy flag shows that a frame is on the line.

Top module: `uart_tx_serial`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `in_ready` is 1 and `busy` is 0. A synchronous reset during a frame returns the block to this state at the next clock edge.
- R2: A frame begins with one start bit at 0. It appears on `tx_line` the cycle after acceptance and lasts 16 baud ticks.
- R3: The data field has `cfg_len` + 5 bits (code 0 gives 5 bits, code 3 gives 8 bits). It is sent from bit 0 upward, and input bits above the selected width are not sent.
- R4: `cfg_parity` code 1 appends one bit that makes the number of ones in data plus parity even. Code 2 makes that number odd. Codes 0 and 3 append no parity bit.
- R5: The stop period is high. It lasts 16 ticks for `cfg_stop` code 0, 24 ticks for code 1, and 32 ticks for codes 2 and 3.
- R6: Every start, data and parity bit lasts exactly 16 baud ticks. A frame therefore lasts 16·(1 + data bits + parity bits) + stop ticks.
- R7: A character is accepted only in a cycle where `in_valid` and `in_ready` are both 1. While a frame is in progress `in_ready` is 0, and `in_valid` is ignored.
- R8: `busy` rises, and `in_ready` falls, in the cycle after acceptance. Both return to idle in the cycle after the clock edge that consumes the last stop tick.
- R9: Character and framing codes are captured at acceptance. Changing the inputs during a frame does not alter that frame.
- R10: In a clock cycle without `baud_tick`, the frame does not advance and `tx_line` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable, 16 per bit time |
| cfg_len | input | 2 | Data width code, width = code + 5 |
| cfg_parity | input | 2 | 0/3 none, 1 even, 2 odd |
| cfg_stop | input | 2 | 0 one bit, 1 one and a half, 2/3 two bits |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character, bit 0 sent first |
| in_ready | output | 1 | Block can accept a character |
| busy | output | 1 | A frame is in progress |
| tx_line | output | 1 | Serial output, high at rest |

## Verification
A character is accepted at a clock edge. The start bit, `busy` and the falling `in_ready` are all due one cycle later, and the bench checks them at the falling edge of that cycle. After that, all timing is counted in ticks. The bench keeps its own count of ticks consumed since acceptance. It samples each bit when its own count reaches the middle of the bit (tick 8 of 16). It expects `in_ready` to return at the first falling edge after the count reaches the computed frame length, and requires it to stay low at every falling edge before that. Pauses in the tick stream and reprogramming during a frame are then judged against the same tick-based schedule.

// File: rtl/uart_tx_pkg.sv
// Package: shared state type and framing helpers for the serial transmitter.
// Assumes data width codes map to 5..8 bits and ticks run at 16 per bit.
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    // Parity is appended for the even (1) and odd (2) codes only.
    function automatic logic parity_enabled(input logic [1:0] code);
        return (code == 2'd1) || (code == 2'd2);
    endfunction

    // Odd mode flips the plain XOR of the data bits.
    function automatic logic parity_invert(input logic [1:0] code);
        return code == 2'd2;
    endfunction

endpackage

// File: rtl/utx_tick_timer.sv
// Module: utx_tick_timer
// Counts baud ticks inside the current bit or stop period and pulses
// 'expire' on the tick that ends it. Assumes 'last_cnt' is held stable
// for the whole period; 'clear' restarts the count and masks any tick.
module utx_tick_timer #(
    parameter int OVERSAMPLE = 16,
    localparam int CNT_W     = $clog2(2 * OVERSAMPLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Period end: a tick arriving while the count sits at its terminal value.
    assign expire = tick && !clear && (cnt_q == last_cnt);

    // Tick counter, wraps to zero at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/utx_frame_latch.sv
// Module: utx_frame_latch
// Captures the framing codes on a load and turns them into the values the
// sequencer needs: index of the last data bit, parity enable and value,
// and the terminal tick count of the stop period.
// Assumes 'load' is only raised while the transmitter is idle.
module utx_frame_latch
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_MAX   = 8,
    localparam int CNT_W     = $clog2(2 * OVERSAMPLE),
    localparam int IDX_W     = $clog2(DATA_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [DATA_MAX-1:0] din,
    input  logic [1:0]          len_code,
    input  logic [1:0]          par_code,
    input  logic [1:0]          stop_code,
    output logic [IDX_W-1:0]    last_idx,
    output logic                par_en,
    output logic                par_bit,
    output logic [CNT_W-1:0]    stop_last
);

    localparam logic [CNT_W-1:0] STOP_ONE  = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] STOP_HALF = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] STOP_TWO  = CNT_W'(2 * OVERSAMPLE - 1);

    logic [IDX_W-1:0]    idx_d;
    logic [DATA_MAX-1:0] keep;
    logic [CNT_W-1:0]    stop_d;

    // Last data index: width code plus four (code 0 -> bit 4).
    assign idx_d = IDX_W'(len_code) + IDX_W'(4);

    // Per-bit mask so that bits above the selected width do not enter the parity.
    for (genvar i = 0; i < DATA_MAX; i++) begin : g_mask
        assign keep[i] = (IDX_W'(i) <= idx_d);
    end

    // Terminal tick count of the stop period for each code.
    always_comb begin
        case (stop_code)
            2'd0:    stop_d = STOP_ONE;
            2'd1:    stop_d = STOP_HALF;
            default: stop_d = STOP_TWO;
        endcase
    end

    // Capture the framing of the accepted character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_idx  <= '0;
            par_en    <= 1'b0;
            par_bit   <= 1'b0;
            stop_last <= STOP_ONE;
        end else if (load) begin
            last_idx  <= idx_d;
            par_en    <= parity_enabled(par_code);
            par_bit   <= (^(din & keep)) ^ parity_invert(par_code);
            stop_last <= stop_d;
        end
    end

endmodule

// File: rtl/utx_sequencer.sv
// Module: utx_sequencer
// Walks a frame through start, data, parity and stop phases on timer
// expiry, shifting the character out least significant bit first.
// Assumes the framing inputs were captured on the same load edge.
module utx_sequencer
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_MAX   = 8,
    localparam int CNT_W     = $clog2(2 * OVERSAMPLE),
    localparam int IDX_W     = $clog2(DATA_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                expire,
    input  logic [DATA_MAX-1:0] din,
    input  logic [IDX_W-1:0]    last_idx,
    input  logic                par_en,
    input  logic                par_bit,
    input  logic [CNT_W-1:0]    stop_last,
    output logic [CNT_W-1:0]    timer_last,
    output logic                idle,
    output logic                line
);

    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);

    tx_state_e           state_q;
    logic [IDX_W-1:0]    idx_q;
    logic [DATA_MAX-1:0] shift_q;

    // The stop phase uses its own length; every other bit is a full bit time.
    assign timer_last = (state_q == TX_STOP) ? stop_last : BIT_LAST;
    assign idle       = (state_q == TX_IDLE);

    // Line level driven by the current phase.
    always_comb begin
        case (state_q)
            TX_START:  line = 1'b0;
            TX_DATA:   line = shift_q[0];
            TX_PARITY: line = par_bit;
            default:   line = 1'b1;
        endcase
    end

    // Phase sequencing and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            idx_q   <= '0;
            shift_q <= '0;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (load) begin
                        state_q <= TX_START;
                        idx_q   <= '0;
                        shift_q <= din;
                    end
                end
                TX_START: begin
                    if (expire) state_q <= TX_DATA;
                end
                TX_DATA: begin
                    if (expire) begin
                        shift_q <= shift_q >> 1;
                        if (idx_q == last_idx) begin
                            idx_q   <= '0;
                            state_q <= par_en ? TX_PARITY : TX_STOP;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                TX_PARITY: begin
                    if (expire) state_q <= TX_STOP;
                end
                TX_STOP: begin
                    if (expire) state_q <= TX_IDLE;
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_serial.sv
// Module: uart_tx_serial (top)
// Asynchronous serial transmitter with per-character framing selection.
// Assumes baud_tick is a one-cycle pulse at 16 times the bit rate and
// that rst_n is synchronous to clk.
module uart_tx_serial #(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_MAX   = 8,
    localparam int CNT_W     = $clog2(2 * OVERSAMPLE),
    localparam int IDX_W     = $clog2(DATA_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic [1:0]          cfg_len,
    input  logic [1:0]          cfg_parity,
    input  logic [1:0]          cfg_stop,
    input  logic                in_valid,
    input  logic [DATA_MAX-1:0] in_data,
    output logic                in_ready,
    output logic                busy,
    output logic                tx_line
);

    logic             load;
    logic             expire;
    logic             idle;
    logic [IDX_W-1:0] last_idx;
    logic             par_en;
    logic             par_bit;
    logic [CNT_W-1:0] stop_last;
    logic [CNT_W-1:0] timer_last;

    // Handshake: a character is taken only while idle.
    assign in_ready = idle;
    assign busy     = !idle;
    assign load     = in_valid && idle;

    utx_frame_latch #(.OVERSAMPLE(OVERSAMPLE), .DATA_MAX(DATA_MAX)) latch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .din       (in_data),
        .len_code  (cfg_len),
        .par_code  (cfg_parity),
        .stop_code (cfg_stop),
        .last_idx  (last_idx),
        .par_en    (par_en),
        .par_bit   (par_bit),
        .stop_last (stop_last)
    );

    utx_tick_timer #(.OVERSAMPLE(OVERSAMPLE)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load),
        .tick     (baud_tick),
        .last_cnt (timer_last),
        .expire   (expire)
    );

    utx_sequencer #(.OVERSAMPLE(OVERSAMPLE), .DATA_MAX(DATA_MAX)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .expire     (expire),
        .din        (in_data),
        .last_idx   (last_idx),
        .par_en     (par_en),
        .par_bit    (par_bit),
        .stop_last  (stop_last),
        .timer_last (timer_last),
        .idle       (idle),
        .line       (tx_line)
    );

endmodule

// File: rtl/utx_checker.sv
// Module: utx_checker
// Port-level properties of the serial transmitter, bound to the top.
module utx_checker (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic tx_line
);

    // Line rests high whenever no frame is in progress.
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    // The first cycle of a frame shows the start bit.
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line);

    // No character is taken while a frame is in progress.
    assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // Acceptance raises busy in the next cycle.
    assert_busy_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !in_ready));

    // Without a tick the line holds.
    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> $stable(tx_line));

endmodule

bind uart_tx_serial utx_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .busy      (busy),
    .tx_line   (tx_line)
);

// File: tb/uart_tx_serial_tb_top.sv
// Directed bench for uart_tx_serial: each scenario task checks its own results.
module uart_tx_serial_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_parity = 2'd0;
    logic [1:0] cfg_stop = 2'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       busy;
    logic       tx_line;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  tick_en = 1'b1;
    int  tick_div = 0;
    int  tick_seen = 0;

    uart_tx_serial dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .cfg_len    (cfg_len),
        .cfg_parity (cfg_parity),
        .cfg_stop   (cfg_stop),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .busy       (busy),
        .tx_line    (tx_line)
    );

    always #2 clk = ~clk;

    // Tick generator: one pulse every four clocks while enabled.
    always @(posedge clk) begin
        tick_div  <= (tick_div + 1) % 4;
        baud_tick <= tick_en && (tick_div == 0);
    end

    // Bench-side count of ticks consumed at clock edges.
    always @(posedge clk) begin
        if (baud_tick) tick_seen <= tick_seen + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1 idle line", int'(tx_line), 1);
        chk(in_ready == 1'b1, "R1 idle ready", int'(in_ready), 1);
        chk(busy == 1'b0, "R1 idle busy", int'(busy), 0);
    endtask

    // mode: 0 plain, 1 poke inputs mid-frame, 2 pause ticks mid-frame
    task automatic run_frame(input logic [7:0] d, input logic [1:0] len,
                             input logic [1:0] par, input logic [1:0] stp,
                             input int mode);
        int   nb;
        int   pe;
        int   total;
        int   base;
        int   k;
        int   last_b;
        logic frm [0:15];
        logic m_par;
        logic held;
        nb    = int'(len) + 5;
        pe    = (par == 2'd1 || par == 2'd2) ? 1 : 0;
        m_par = 1'b0;
        for (int i = 0; i < nb; i++) m_par ^= d[i];
        if (par == 2'd2) m_par = ~m_par;
        for (int i = 0; i < 16; i++) frm[i] = 1'b1;
        frm[0] = 1'b0;
        for (int i = 0; i < nb; i++) frm[1 + i] = d[i];
        if (pe == 1) frm[1 + nb] = m_par;
        total = 16 * (1 + nb + pe) + ((stp == 2'd0) ? 16 : (stp == 2'd1) ? 24 : 32);

        @(negedge clk);
        cfg_len = len; cfg_parity = par; cfg_stop = stp;
        in_data = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        base = tick_seen;
        chk(busy == 1'b1 && in_ready == 1'b0, "R8 busy after accept", int'(busy), 1);
        chk(tx_line == 1'b0, "R2 start bit", int'(tx_line), 0);
        last_b = -1;
        k = 0;
        while (k < total) begin
            k = tick_seen - base;
            if (k >= total) break;
            chk(in_ready == 1'b0, "R6 R8 ready low within frame", int'(in_ready), 0);
            if (k % 16 == 8 && (k / 16) != last_b) begin
                last_b = k / 16;
                if (last_b == 0)
                    chk(tx_line == frm[0], "R2 start mid", int'(tx_line), int'(frm[0]));
                else if (last_b <= nb)
                    chk(tx_line == frm[last_b], "R3 data bit", int'(tx_line), int'(frm[last_b]));
                else if (pe == 1 && last_b == nb + 1)
                    chk(tx_line == frm[last_b], "R4 parity bit", int'(tx_line), int'(frm[last_b]));
                else
                    chk(tx_line == 1'b1, "R5 stop level", int'(tx_line), 1);
            end
            if (mode == 1 && k == 40) begin
                in_valid = 1'b1; in_data = ~d;
                cfg_len = ~len; cfg_parity = ~par; cfg_stop = ~stp;
                @(negedge clk);
                in_valid = 1'b0;
                chk(busy == 1'b1, "R7 load while busy ignored", int'(busy), 1);
                mode = 0;
            end else if (mode == 2 && k == 50) begin
                tick_en = 1'b0;
                repeat (3) @(negedge clk);
                held = tx_line;
                for (int c = 0; c < 30; c++) begin
                    @(negedge clk);
                    chk(tx_line == held && busy == 1'b1, "R10 hold without tick", int'(tx_line), int'(held));
                end
                tick_en = 1'b1;
                mode = 0;
            end else begin
                @(negedge clk);
            end
        end
        chk(in_ready == 1'b1 && busy == 1'b0, "R5 R6 R8 ready at frame end", int'(in_ready), 1);
        chk(tx_line == 1'b1, "R1 line idle after frame", int'(tx_line), 1);
    endtask

    task automatic t_idle_after_poke();
        repeat (80) @(negedge clk);
        chk(tx_line == 1'b1 && in_ready == 1'b1, "R7 R9 no second frame", int'(tx_line), 1);
    endtask

    task automatic t_reset_mid_frame();
        @(negedge clk);
        cfg_len = 2'd3; cfg_parity = 2'd0; cfg_stop = 2'd0;
        in_data = 8'h00; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (200) @(negedge clk);
        chk(busy == 1'b1, "R1 frame running before reset", int'(busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(tx_line == 1'b1 && in_ready == 1'b1 && busy == 1'b0, "R1 reset mid frame",
            int'(tx_line), 1);
    endtask

    initial begin
        t_reset();
        run_frame(8'h35, 2'd3, 2'd0, 2'd0, 0);  // 8 bits, none, 1 stop
        run_frame(8'hA6, 2'd2, 2'd1, 2'd2, 0);  // 7 bits, even, 2 stop
        run_frame(8'hFF, 2'd0, 2'd2, 2'd1, 0);  // 5 bits, odd, 1.5 stop, upper bits dropped
        run_frame(8'h00, 2'd1, 2'd2, 2'd3, 0);  // 6 bits, odd of zeros, stop code 3
        run_frame(8'h6B, 2'd1, 2'd3, 2'd1, 0);  // parity code 3 sends none
        run_frame(8'h5A, 2'd3, 2'd1, 2'd1, 1);  // R9 inputs changed mid-frame
        t_idle_after_poke();
        run_frame(8'hC3, 2'd2, 2'd0, 2'd0, 2);  // R10 tick pause
        run_frame(8'h81, 2'd3, 2'd2, 2'd2, 0);
        t_reset_mid_frame();
        run_frame(8'h9C, 2'd3, 2'd1, 2'd0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule